// File: doc/BRIEF.md
# In-Order Retire Scoreboard with Reorder Buffer

This block keeps track of every instruction that a single-issue, in-order pipeline has sent to its functional units but not yet retired. One circular buffer does two jobs. As a scoreboard, it tells the issue stage whether each source register of the next instruction is still being produced by an in-flight instruction. As a reorder buffer, it holds results that finish out of order and releases them to the register file in program order.

Each issued instruction takes the slot at the tail pointer. That slot index is the instruction's transaction ID, and the functional units quote it on their write-back ports. Several write-back ports may land results in the same cycle without colliding. When the entry at the head pointer holds a result, it is presented on the single commit port and retires at the next clock edge. Every entry that has not retired is speculative. A flush input, or the retirement of an entry that carries an exception, drops all of these entries at once and leaves the register file untouched.

When a source register matches the destination of the youngest in-flight writer, the block does one of two things. If that writer has its result, the value is forwarded. If it does not, a busy flag is raised and the issue stage must hold.

Top module: `sb_rob`

## Requirements
- R1: An instruction is accepted when `issue_valid_i` and `issue_ready_o` are both high at a clock edge. It takes the ID shown on `issue_id_o`. IDs are handed out in sequence 0, 1, …, DEPTH-1 and then wrap to 0.
- R2: `issue_ready_o` is low while DEPTH entries are held. A request made in that state is dropped and creates no entry. The first retirement raises `issue_ready_o` again.
- R3: A write-back port whose `wb_valid_i` bit is high at a clock edge stores its data and exception bit into the occupied entry named by its ID field. Ports may complete entries in any order. Port p uses bits `[p*IW +: IW]` of `wb_id_i` and `[p*XLEN +: XLEN]` of `wb_data_i`.
- R4: `commit_valid_o` is high exactly when the oldest entry holds its result. That entry retires at that clock edge. A completed younger entry waits until every older entry has retired.
- R5: On a retirement without exception, `commit_we_o` is high and `commit_rd_o`/`commit_data_o` carry the entry's destination and result.
- R6: On a retirement whose entry carries an exception, `exc_o` is high, `commit_we_o` is low and `issue_ready_o` is low. After that edge every younger entry is gone and `issue_id_o` returns to 0.
- R7: `flush_i` discards every entry at the clock edge, hides `commit_valid_o` and blocks issue in that cycle. The next issued instruction gets ID 0.
- R8: For each source register, the youngest entry writing it decides the outcome. If that entry holds its result, `fwd` is high and `data` carries the result. If it does not, `busy` is high. With no such entry, both flags and `data` are 0.
- R9: Register 0 as a source never raises `busy` or `fwd`.
- R10: A write-back aimed at an unoccupied slot changes nothing. A later instruction placed in that slot starts without a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all uncommitted entries |
| issue_valid_i | input | 1 | Issue request |
| issue_rd_i | input | 5 | Destination register of issued instruction |
| issue_ready_o | output | 1 | Buffer can accept an instruction |
| issue_id_o | output | IW | ID the next issued instruction receives |
| rs1_i | input | 5 | First source register to look up |
| rs2_i | input | 5 | Second source register to look up |
| rs1_busy_o | output | 1 | First source pending, stall |
| rs1_fwd_o | output | 1 | First source forwarded from buffer |
| rs1_data_o | output | XLEN | Forwarded value for first source |
| rs2_busy_o | output | 1 | Second source pending, stall |
| rs2_fwd_o | output | 1 | Second source forwarded from buffer |
| rs2_data_o | output | XLEN | Forwarded value for second source |
| wb_valid_i | input | NR_WB | Per-port write-back strobe |
| wb_id_i | input | NR_WB*IW | Per-port target ID |
| wb_data_i | input | NR_WB*XLEN | Per-port result |
| wb_exc_i | input | NR_WB | Per-port exception flag |
| commit_valid_o | output | 1 | Oldest entry retires this cycle |
| commit_id_o | output | IW | ID of the retiring entry |
| commit_rd_o | output | 5 | Destination of the retiring entry |
| commit_data_o | output | XLEN | Result of the retiring entry |
| commit_we_o | output | 1 | Register file write enable |
| exc_o | output | 1 | Retiring entry carries an exception |

## Verification
The bench builds the block with DEPTH 4, two write-back ports and a 16-bit result path. With only four slots, the full condition and the wrap of the IDs back past slot 0 show up within a few issues, so the stall and a wrapped head pointer are both covered.

Two ports let the bench complete two entries out of order in one cycle, including one writer that shadows an older writer of the same register. The same build also reaches an exception retirement with completed younger entries behind it, and a flush that coincides with an issue request.

// File: rtl/sb_rob_pkg.sv
package sb_rob_pkg;
  localparam int REG_AW = 5;
  typedef logic [REG_AW-1:0] reg_idx_t;
  localparam reg_idx_t REG_ZERO = '0;
endpackage

// File: rtl/sb_rob_ptrs.sv
module sb_rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic          retire_i,
  input  logic          clear_i,
  output logic [IW-1:0] head_o,
  output logic [IW-1:0] tail_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (alloc_i)  tail_q <= bump(tail_q);
      if (retire_i) head_q <= bump(head_q);
      if (alloc_i && !retire_i)      cnt_q <= cnt_q + 1'b1;
      else if (!alloc_i && retire_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) full_o |-> !alloc_i); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) retire_i |-> !empty_o); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni) clear_i |=> (empty_o && tail_o == '0)); // R7
endmodule

// File: rtl/sb_rob_lookup.sv
module sb_rob_lookup
  import sb_rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int XLEN  = 64,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [IW-1:0]           head_i,
  input  reg_idx_t                rs_i,
  input  logic [DEPTH-1:0]        valid_i,
  input  logic [DEPTH-1:0]        done_i,
  input  logic [DEPTH*REG_AW-1:0] rd_i,
  input  logic [DEPTH*XLEN-1:0]   data_i,
  output logic                    busy_o,
  output logic                    fwd_o,
  output logic [XLEN-1:0]         data_o
);
  logic hit;
  int   hidx;

  // scan oldest to youngest; last match is the youngest writer
  always_comb begin
    hit  = 1'b0;
    hidx = 0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = int'(head_i) + k;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if (valid_i[idx] && rd_i[idx*REG_AW +: REG_AW] == rs_i && rs_i != REG_ZERO) begin
        hit  = 1'b1;
        hidx = idx;
      end
    end
  end

  assign busy_o = hit && !done_i[hidx];
  assign fwd_o  = hit && done_i[hidx];
  assign data_o = fwd_o ? data_i[hidx*XLEN +: XLEN] : '0;

  AST_BUSY_FWD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(busy_o && fwd_o)); // R8
  AST_X0_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni) (rs_i == REG_ZERO) |-> (!busy_o && !fwd_o)); // R9
endmodule

// File: rtl/sb_rob.sv
module sb_rob
  import sb_rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int XLEN  = 64,
  parameter int NR_WB = 2,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  issue_valid_i,
  input  logic [REG_AW-1:0]     issue_rd_i,
  output logic                  issue_ready_o,
  output logic [IW-1:0]         issue_id_o,
  input  logic [REG_AW-1:0]     rs1_i,
  input  logic [REG_AW-1:0]     rs2_i,
  output logic                  rs1_busy_o,
  output logic                  rs1_fwd_o,
  output logic [XLEN-1:0]       rs1_data_o,
  output logic                  rs2_busy_o,
  output logic                  rs2_fwd_o,
  output logic [XLEN-1:0]       rs2_data_o,
  input  logic [NR_WB-1:0]      wb_valid_i,
  input  logic [NR_WB*IW-1:0]   wb_id_i,
  input  logic [NR_WB*XLEN-1:0] wb_data_i,
  input  logic [NR_WB-1:0]      wb_exc_i,
  output logic                  commit_valid_o,
  output logic [IW-1:0]         commit_id_o,
  output logic [REG_AW-1:0]     commit_rd_o,
  output logic [XLEN-1:0]       commit_data_o,
  output logic                  commit_we_o,
  output logic                  exc_o
);
  logic [DEPTH-1:0]        valid_q, done_q, exc_q;
  logic [DEPTH*REG_AW-1:0] rd_q;
  logic [DEPTH*XLEN-1:0]   data_q;
  logic [IW-1:0]           head, tail;
  logic                    full, empty, alloc, retire, clear;

  // per-slot write-back decode; higher port wins on a clash
  logic [DEPTH-1:0] wb_hit, wb_x;
  logic [XLEN-1:0]  wb_val [DEPTH];

  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      wb_hit[s] = 1'b0;
      wb_x[s]   = 1'b0;
      wb_val[s] = '0;
      for (int p = 0; p < NR_WB; p++) begin
        if (wb_valid_i[p] && wb_id_i[p*IW +: IW] == IW'(s)) begin
          wb_hit[s] = 1'b1;
          wb_x[s]   = wb_exc_i[p];
          wb_val[s] = wb_data_i[p*XLEN +: XLEN];
        end
      end
    end
  end

  assign commit_valid_o = valid_q[head] && done_q[head] && !flush_i;
  assign exc_o          = commit_valid_o && exc_q[head];
  assign commit_we_o    = commit_valid_o && !exc_q[head];
  assign commit_id_o    = head;
  assign commit_rd_o    = rd_q[head*REG_AW +: REG_AW];
  assign commit_data_o  = data_q[head*XLEN +: XLEN];

  assign clear         = flush_i || exc_o;
  assign issue_ready_o = !full && !clear;
  assign issue_id_o    = tail;
  assign alloc         = issue_valid_i && issue_ready_o;
  assign retire        = commit_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      done_q  <= '0;
      exc_q   <= '0;
      rd_q    <= '0;
      data_q  <= '0;
    end else if (clear) begin
      valid_q <= '0;
      done_q  <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (wb_hit[s] && valid_q[s]) begin
          done_q[s]                 <= 1'b1;
          exc_q[s]                  <= wb_x[s];
          data_q[s*XLEN +: XLEN]    <= wb_val[s];
        end
        if (retire && head == IW'(s)) begin
          valid_q[s] <= 1'b0;
          done_q[s]  <= 1'b0;
        end
        if (alloc && tail == IW'(s)) begin
          valid_q[s]                <= 1'b1;
          done_q[s]                 <= 1'b0;
          exc_q[s]                  <= 1'b0;
          rd_q[s*REG_AW +: REG_AW]  <= issue_rd_i;
        end
      end
    end
  end

  sb_rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i, .rst_ni,
    .alloc_i(alloc), .retire_i(retire), .clear_i(clear),
    .head_o(head), .tail_o(tail), .full_o(full), .empty_o(empty)
  );

  sb_rob_lookup #(.DEPTH(DEPTH), .XLEN(XLEN)) u_look_rs1 (
    .clk_i, .rst_ni, .head_i(head), .rs_i(rs1_i),
    .valid_i(valid_q), .done_i(done_q), .rd_i(rd_q), .data_i(data_q),
    .busy_o(rs1_busy_o), .fwd_o(rs1_fwd_o), .data_o(rs1_data_o)
  );

  sb_rob_lookup #(.DEPTH(DEPTH), .XLEN(XLEN)) u_look_rs2 (
    .clk_i, .rst_ni, .head_i(head), .rs_i(rs2_i),
    .valid_i(valid_q), .done_i(done_q), .rd_i(rd_q), .data_i(data_q),
    .busy_o(rs2_busy_o), .fwd_o(rs2_fwd_o), .data_o(rs2_data_o)
  );

  AST_COMMIT_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni) commit_valid_o |-> !empty); // R4
  AST_EXC_KILLS_YOUNGER: assert property (@(posedge clk_i) disable iff (!rst_ni) exc_o |=> (!commit_valid_o && issue_id_o == '0)); // R6
  AST_FLUSH_NO_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni) flush_i |-> (!issue_ready_o && !commit_valid_o)); // R7
endmodule

// File: tb/sb_rob_bench.sv
module sb_rob_bench;
  localparam int DEPTH = 4;
  localparam int XLEN  = 16;
  localparam int NR_WB = 2;
  localparam int IW    = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic flush, iv, iready, rs1b, rs1f, rs2b, rs2f, cv, cwe, exc;
  logic [4:0] ird, rs1, rs2, crd;
  logic [IW-1:0] iid, cid;
  logic [XLEN-1:0] rs1d, rs2d, cdata;
  logic [NR_WB-1:0] wbv, wbx;
  logic [NR_WB*IW-1:0] wbid;
  logic [NR_WB*XLEN-1:0] wbd;

  sb_rob #(.DEPTH(DEPTH), .XLEN(XLEN), .NR_WB(NR_WB)) u_sb_rob (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .issue_valid_i(iv), .issue_rd_i(ird), .issue_ready_o(iready), .issue_id_o(iid),
    .rs1_i(rs1), .rs2_i(rs2),
    .rs1_busy_o(rs1b), .rs1_fwd_o(rs1f), .rs1_data_o(rs1d),
    .rs2_busy_o(rs2b), .rs2_fwd_o(rs2f), .rs2_data_o(rs2d),
    .wb_valid_i(wbv), .wb_id_i(wbid), .wb_data_i(wbd), .wb_exc_i(wbx),
    .commit_valid_o(cv), .commit_id_o(cid), .commit_rd_o(crd),
    .commit_data_o(cdata), .commit_we_o(cwe), .exc_o(exc)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic iv; logic [4:0] ird; logic [4:0] rs1;
    logic w0v; logic [1:0] w0id; logic [15:0] w0d;
    logic w1v; logic [1:0] w1id; logic [15:0] w1d;
    logic ecv; logic [4:0] erd; logic [15:0] ecd;
    logic ebusy; logic efwd; logic [15:0] efd; logic [1:0] eid;
  } vec_t;

  // stimulus applied for one edge, then expected outputs after it
  localparam vec_t TBL [8] = '{
    '{1'b1, 5'd1, 5'd1, 1'b0, 2'd0, 16'h0,  1'b0, 2'd0, 16'h0,  1'b0, 5'd0, 16'h0,  1'b1, 1'b0, 16'h0,  2'd1},
    '{1'b1, 5'd2, 5'd2, 1'b0, 2'd0, 16'h0,  1'b0, 2'd0, 16'h0,  1'b0, 5'd0, 16'h0,  1'b1, 1'b0, 16'h0,  2'd2},
    '{1'b0, 5'd0, 5'd2, 1'b1, 2'd1, 16'h22, 1'b0, 2'd0, 16'h0,  1'b0, 5'd0, 16'h0,  1'b0, 1'b1, 16'h22, 2'd2},
    '{1'b1, 5'd1, 5'd1, 1'b0, 2'd0, 16'h0,  1'b0, 2'd0, 16'h0,  1'b0, 5'd0, 16'h0,  1'b1, 1'b0, 16'h0,  2'd3},
    '{1'b0, 5'd0, 5'd1, 1'b1, 2'd0, 16'h11, 1'b1, 2'd2, 16'h33, 1'b1, 5'd1, 16'h11, 1'b0, 1'b1, 16'h33, 2'd3},
    '{1'b0, 5'd0, 5'd1, 1'b0, 2'd0, 16'h0,  1'b0, 2'd0, 16'h0,  1'b1, 5'd2, 16'h22, 1'b0, 1'b1, 16'h33, 2'd3},
    '{1'b0, 5'd0, 5'd2, 1'b0, 2'd0, 16'h0,  1'b0, 2'd0, 16'h0,  1'b1, 5'd1, 16'h33, 1'b0, 1'b0, 16'h0,  2'd3},
    '{1'b0, 5'd0, 5'd0, 1'b0, 2'd0, 16'h0,  1'b0, 2'd0, 16'h0,  1'b0, 5'd0, 16'h0,  1'b0, 1'b0, 16'h0,  2'd3}
  };

  task automatic idle();
    iv = 0; ird = 0; flush = 0; wbv = 0; wbx = 0; wbid = 0; wbd = 0;
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic wb0(input logic [1:0] id, input logic [15:0] d, input logic x);
    wbv[0] = 1; wbid[1:0] = id; wbd[15:0] = d; wbx[0] = x;
  endtask

  task automatic issue(input logic [4:0] rd);
    idle(); iv = 1; ird = rd; tick();
  endtask

  initial begin
    idle(); rs1 = 0; rs2 = 0;
    #35 rst_n = 1'b1;
    tick();
    chk("reset ready R2", iready, 1);
    chk("reset commit R4", cv, 0);
    chk("reset id R1", iid, 0);
    chk("reset exc R6", exc, 0);

    foreach (TBL[i]) begin
      idle();
      iv = TBL[i].iv; ird = TBL[i].ird; rs1 = TBL[i].rs1;
      wbv = {TBL[i].w1v, TBL[i].w0v};
      wbid = {TBL[i].w1id, TBL[i].w0id};
      wbd = {TBL[i].w1d, TBL[i].w0d};
      tick();
      chk("table commit_valid R4", cv, TBL[i].ecv);
      if (TBL[i].ecv) begin
        chk("table commit_rd R5", crd, TBL[i].erd);
        chk("table commit_data R3", cdata, TBL[i].ecd);
      end
      chk("table busy R8", rs1b, TBL[i].ebusy);
      chk("table fwd R8", rs1f, TBL[i].efwd);
      chk("table fwd data R8", rs1d, TBL[i].efd);
      chk("table issue id R1", iid, TBL[i].eid);
    end

    // fill: slots 3,0,1,2
    rs2 = 5;
    issue(5); issue(6); issue(7); issue(8);
    chk("full ready R2", iready, 0);
    chk("wrap id R1", iid, 3);
    chk("rs2 busy R8", rs2b, 1);
    idle(); iv = 1; ird = 9; wb0(2'd3, 16'h55, 0); tick();
    chk("commit valid R4", cv, 1);
    chk("commit we R5", cwe, 1);
    chk("commit rd R5", crd, 5);
    chk("commit data R5", cdata, 16'h55);
    chk("commit id R4", cid, 3);
    chk("still full R2", iready, 0);
    idle(); rs1 = 9; tick();
    chk("ready after retire R2", iready, 1);
    chk("dropped issue R2", rs1b, 0);
    chk("head waits R4", cv, 0);

    // exception at head, younger completed alongside
    idle(); rs1 = 7; wb0(2'd0, 16'h66, 1);
    wbv[1] = 1; wbid[3:2] = 2'd1; wbd[31:16] = 16'h77;
    tick();
    chk("exc out R6", exc, 1);
    chk("exc no write R6", cwe, 0);
    chk("exc blocks issue R6", iready, 0);
    chk("exc rd R6", crd, 6);
    idle(); tick();
    chk("younger dropped R6", cv, 0);
    chk("younger fwd gone R6", rs1f, 0);
    chk("id restart R6", iid, 0);
    chk("exc cleared R6", exc, 0);

    // x0
    rs1 = 0;
    issue(0);
    chk("x0 busy R9", rs1b, 0);
    idle(); wb0(2'd0, 16'h99, 0); tick();
    chk("x0 fwd R9", rs1f, 0);
    idle(); tick();

    // write-back to empty slot 2, then allocate it
    idle(); wb0(2'd2, 16'hAA, 0); tick();
    chk("stray wb no commit R10", cv, 0);
    rs1 = 11;
    issue(10); issue(11);
    chk("stray wb ignored R10", rs1b, 1);
    chk("stray wb no fwd R10", rs1f, 0);

    // flush with simultaneous issue
    idle(); flush = 1; iv = 1; ird = 12; rs1 = 11; tick();
    chk("flush id R7", iid, 0);
    chk("flush commit R7", cv, 0);
    chk("flush busy R7", rs1b, 0);
    idle(); rs1 = 12; tick();
    chk("flushed issue dropped R7", rs1b, 0);
    chk("flush ready R7", iready, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule